// File: doc/BRIEF.md
# Three-State Phase-Frequency Comparator with Lock Flag

This block sits at the heart of a clocked frequency synthesizer loop. It compares two event streams: a reference strobe and the strobe from the divided feedback path. Each event arrives as a single-cycle pulse, and both streams are synchronous to one system clock. From these it produces a three-state correction signal that an external loop filter integrates to steer a VCO. The signal is driven high to pull a slow feedback up and driven low to pull a fast feedback down. At all other times it is released to high impedance, so that the filter holds its charge.

The comparison responds to both phase and frequency. A reference event that finds no feedback event pending opens a pump-up interval. A feedback event that finds no reference event pending opens a pump-down interval. When the second of the two events arrives, the open interval closes. If both events land in the same cycle, no interval opens at all. The lock flag rests high and falls only for the cycles in which a correction interval is open, so a loop that is in lock shows a steady high level.

The correction output is formed inside the block from a drive value and an enable. Both are also brought out as plain signals, so that neighbouring digital logic can observe them without resolving a tri-state net.

Top module: `phase_freq_cmp`

## Requirements
- R1: While reset (rstN low) is asserted, and in the first cycle after it is released, pdEnable is 0 and lockOk is 1.
- R2: Consider a refPulse with no fbPulse in the same cycle, arriving while no interval is open. From the next cycle, pdEnable=1 and pdDrive=1 (pump up).
- R3: Consider an fbPulse with no refPulse in the same cycle, arriving while no interval is open. From the next cycle, pdEnable=1 and pdDrive=0 (pump down).
- R4: An open interval closes on the clock edge that samples the opposite event, so pdEnable is 0 in the following cycle. The up interval therefore lasts exactly the number of cycles from the reference event to the feedback event.
- R5: When refPulse and fbPulse are high in the same cycle while no interval is open, pdEnable stays 0 in the next cycle.
- R6: lockOk is 0 in exactly the cycles in which pdEnable is 1, and 1 in all other cycles.
- R7: Further refPulse events during an open up interval do not extend or stack it. A single later fbPulse closes it, and the cycle after that shows pdEnable=0. The same holds with the roles swapped for a down interval.
- R8: In every cycle with pdEnable=1, the tri-state port pdOut carries the value of pdDrive.
- R9: When both pulses arrive in the same cycle while an interval is already open, the interval closes, and pdEnable is 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all logic samples on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| refPulse | input | 1 | Single-cycle reference event |
| fbPulse | input | 1 | Single-cycle divided-feedback event |
| pdOut | output | 1 | Tri-state correction output: 1 pump up, 0 pump down, Z released |
| pdDrive | output | 1 | Drive value behind pdOut (1 = up) |
| pdEnable | output | 1 | Output enable behind pdOut |
| lockOk | output | 1 | Lock flag, 0 while a correction interval is open |

## Verification
The bench runs lagging, leading and coincident feedback streams, and it checks drive, enable and lock in every cycle against a scoreboard model built from the requirements. A design that opens both intervals on coincident pulses would show a one-cycle enable pulse, and a design that clears one cycle late would stretch every interval by a cycle; both show up as per-cycle enable mismatches. Extra reference pulses inside an open interval, and a coincident pair arriving while an interval is open, are aimed at designs that count events or ignore the pair. Such designs would leave the enable high after the closing event.

// File: rtl/phase_freq_cmp_pkg.sv
package phase_freq_cmp_pkg;

  // Strobes from the event decoder to the state/output datapath
  typedef struct packed {
    logic openUp;    // start pump-up interval
    logic openDn;    // start pump-down interval
    logic closeAll;  // both events seen: end any interval
  } pfdStrobe_t;

endpackage

// File: rtl/pfd_ctrl.sv
module pfd_ctrl
  import phase_freq_cmp_pkg::*;
(
  input  logic       refPulse,
  input  logic       fbPulse,
  input  logic       upState,
  input  logic       dnState,
  output pfdStrobe_t strobe
);

  logic refSeen;
  logic fbSeen;

  always_comb begin
    // An event counts as seen if it is arriving now or is already pending
    refSeen         = refPulse | upState;
    fbSeen          = fbPulse | dnState;
    strobe.closeAll = refSeen & fbSeen;
    strobe.openUp   = refPulse & ~strobe.closeAll;
    strobe.openDn   = fbPulse & ~strobe.closeAll;
  end

endmodule

// File: rtl/pfd_path.sv
module pfd_path
  import phase_freq_cmp_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  pfdStrobe_t strobe,
  output logic       upState,
  output logic       dnState,
  output logic       driveVal,
  output logic       driveEn,
  output logic       lockFlag
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      upState <= 1'b0;
      dnState <= 1'b0;
    end else if (strobe.closeAll) begin
      upState <= 1'b0;
      dnState <= 1'b0;
    end else begin
      upState <= upState | strobe.openUp;
      dnState <= dnState | strobe.openDn;
    end
  end

  always_comb begin
    driveEn  = upState | dnState;
    driveVal = upState;
    lockFlag = ~(upState | dnState);
  end

endmodule

// File: rtl/phase_freq_cmp.sv
module phase_freq_cmp
  import phase_freq_cmp_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic refPulse,
  input  logic fbPulse,
  output wire  pdOut,
  output logic pdDrive,
  output logic pdEnable,
  output logic lockOk
);

  pfdStrobe_t strobe;
  logic       upState;
  logic       dnState;

  pfd_ctrl i_ctrl (
    .refPulse (refPulse),
    .fbPulse  (fbPulse),
    .upState  (upState),
    .dnState  (dnState),
    .strobe   (strobe)
  );

  pfd_path i_path (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .upState  (upState),
    .dnState  (dnState),
    .driveVal (pdDrive),
    .driveEn  (pdEnable),
    .lockFlag (lockOk)
  );

  assign pdOut = pdEnable ? pdDrive : 1'bz;

endmodule

// File: rtl/phase_freq_cmp_chk.sv
module phase_freq_cmp_chk (
  input logic clk,
  input logic rstN,
  input logic refPulse,
  input logic fbPulse,
  input logic pdDrive,
  input logic pdEnable,
  input logic lockOk
);

  // R1
  always @(negedge clk) begin
    if (!rstN) begin
      reset_idle_chk: assert (!pdEnable && lockOk)
        else $error("reset state wrong");
    end
  end

  // R2
  up_open_chk: assert property (@(posedge clk) disable iff (!rstN)
    (refPulse && !fbPulse && !pdEnable) |=> (pdEnable && pdDrive));

  // R3
  dn_open_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fbPulse && !refPulse && !pdEnable) |=> (pdEnable && !pdDrive));

  // R4
  up_close_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pdEnable && pdDrive && fbPulse) |=> !pdEnable);

  // R5
  coincide_chk: assert property (@(posedge clk) disable iff (!rstN)
    (refPulse && fbPulse && !pdEnable) |=> !pdEnable);

  // R6
  lock_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    lockOk != pdEnable);

  // R7
  up_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pdEnable && pdDrive && !fbPulse) |=> (pdEnable && pdDrive));

  // R7
  dn_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pdEnable && !pdDrive && !refPulse) |=> (pdEnable && !pdDrive));

  // R9
  pair_close_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pdEnable && refPulse && fbPulse) |=> !pdEnable);

endmodule

bind phase_freq_cmp phase_freq_cmp_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .refPulse (refPulse),
  .fbPulse  (fbPulse),
  .pdDrive  (pdDrive),
  .pdEnable (pdEnable),
  .lockOk   (lockOk)
);

// File: tb/test_phase_freq_cmp.sv
module test_phase_freq_cmp;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  typedef struct {
    logic  en;
    logic  drv;
    string req;
  } expItem_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic refPulse = 1'b0;
  logic fbPulse = 1'b0;
  wire  pdOut;
  logic pdDrive;
  logic pdEnable;
  logic lockOk;

  int checks = 0;
  int errors = 0;
  expItem_t expQ[$];
  logic pendUp = 1'b0;
  logic pendDn = 1'b0;
  bit   done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  phase_freq_cmp i_phase_freq_cmp (
    .clk      (clk),
    .rstN     (rstN),
    .refPulse (refPulse),
    .fbPulse  (fbPulse),
    .pdOut    (pdOut),
    .pdDrive  (pdDrive),
    .pdEnable (pdEnable),
    .lockOk   (lockOk)
  );

  task automatic check(input string req, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
    end
  endtask

  // Driver: one cycle of stimulus, plus the expected state after the next edge
  task automatic step(input logic r, input logic f);
    expItem_t it;
    logic wasOpen;
    @(negedge clk);
    refPulse = r;
    fbPulse  = f;
    wasOpen  = pendUp | pendDn;
    if ((r | pendUp) && (f | pendDn)) begin
      it.req = (r && f) ? (wasOpen ? "R9" : "R5") : "R4";
      pendUp = 1'b0;
      pendDn = 1'b0;
    end else begin
      if (r && pendUp) it.req = "R7";
      else if (f && pendDn) it.req = "R7";
      else if (r) it.req = "R2";
      else if (f) it.req = "R3";
      else it.req = wasOpen ? "R7" : "R4";
      pendUp = pendUp | r;
      pendDn = pendDn | f;
    end
    it.en  = pendUp | pendDn;
    it.drv = pendUp;
    expQ.push_back(it);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0);
  endtask

  // Reference period of per, feedback offset by off cycles (negative = leads)
  task automatic stream(input int per, input int off, input int reps);
    for (int k = 0; k < reps; k++) begin
      for (int c = 0; c < per; c++) begin
        step(c == per / 2, c == per / 2 + off);
      end
    end
  endtask

  // Monitor: compares every cycle after the edge settles
  initial begin
    expItem_t it;
    forever begin
      @(posedge clk);
      #2;
      if (expQ.size() > 0) begin
        it = expQ.pop_front();
        check(it.req, pdEnable, it.en, "pdEnable");
        if (it.en) check(it.req, pdDrive, it.drv, "pdDrive");
        // R6
        check("R6", lockOk, ~it.en, "lockOk");
        // R8
        if (it.en) check("R8", pdOut, it.drv, "pdOut");
      end
    end
  end

  initial begin
    fork
      begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
          errors++;
          checks++;
          $display("FAIL watchdog expired actual=running expected=finished");
          $display("  CHECKS %0d ERRORS %0d", checks, errors);
          $finish;
        end
      end
    join_none

    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: during reset
    check("R1", pdEnable, 1'b0, "pdEnable in reset");
    check("R1", lockOk, 1'b1, "lockOk in reset");
    rstN = 1'b1;
    @(posedge clk);
    #2;
    // R1: first cycle after release
    check("R1", pdEnable, 1'b0, "pdEnable after reset");
    check("R1", lockOk, 1'b1, "lockOk after reset");

    // Lagging feedback: ref leads by 5 cycles (R2, R4)
    stream(16, 5, 4);
    // Leading feedback: fb arrives 4 cycles before ref (R3, R4)
    stream(16, -4, 4);
    // Coincident events (R5)
    stream(12, 0, 4);
    // Adjacent-cycle events: one-cycle interval each way
    stream(10, 1, 2);
    stream(10, -1, 2);
    // R7: repeated ref during an up interval, then one fb
    step(1, 0); step(1, 0); idle(2); step(1, 0); step(0, 1); idle(3);
    // R7: repeated fb during a down interval, then one ref
    step(0, 1); idle(1); step(0, 1); step(1, 0); idle(3);
    // R9: both pulses while an up interval is open
    step(1, 0); idle(2); step(1, 1); idle(3);
    // R9: both pulses while a down interval is open
    step(0, 1); step(1, 1); idle(3);
    idle(2);

    while (expQ.size() > 0) @(posedge clk);
    @(posedge clk);
    #3;
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule